// File: doc/BRIEF.md
# Flash Sector Write-Protection Controller

This block sits in front of the program and erase machinery of a small parallel flash array of seven sectors, with sector 6 as the 16-Kbyte top boot sector. For every program or erase request it decides whether the operation may start. The decision combines two active-low hardware guard pins with a bank of per-sector software write-lock bits.

The protected set depends on the command. A program or standard sector erase looks at one sector. The boot guard pin covers sector 6, and the general write-guard pin covers sectors 0 to 5. A uniform 64-Kbyte erase works on a region. The top region (sectors 3 to 6) is covered only by the boot guard pin. The lower region (sectors 0 to 2) is covered only by the write-guard pin.

Either of two active-low reset inputs puts the block back in read-array mode and relocks every sector. If an operation is in flight when reset arrives, that operation is aborted. After reset is released, a programmable recovery interval runs. Until it ends, commands and lock writes are dropped without any response.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While `boot_lock_n` is 0, a program (`cmd_op`=0) or sector erase (`cmd_op`=1) aimed at sector 6 is rejected. `boot_lock_n` has no effect on these commands for sectors 0 to 5.
- R2: While `wr_prot_n` is 0, a program or sector erase aimed at sectors 0 to 5 is rejected. `wr_prot_n` has no effect on these commands for sector 6.
- R3: A uniform erase (`cmd_op`=2) with `cmd_sect` in 3..6 targets sectors 3 to 6. It is accepted only when `boot_lock_n` is 1 and the lock bits of sectors 3 to 6 are all clear. With `cmd_sect` in 0..2 it targets sectors 0 to 2, and it then needs `wr_prot_n` at 1 and the lock bits of sectors 0 to 2 clear.
- R4: A command that reaches the decision produces exactly one response one clock later. The response is a one-cycle `cmd_ack` when the guarding pin is high and the target lock bit is clear, and a one-cycle `cmd_nak` otherwise.
- R5: Any cycle in which `rst_a_n` or `rst_b_n` is 0 sets every lock bit to 1 (locked). Outside reset, a `lock_we` pulse writes `lock_val` into the bit of sector `lock_sect` (1 = locked).
- R6: After reset is released, `ready` rises after exactly RECOV_CYCLES clock cycles. Before that, commands get neither `cmd_ack` nor `cmd_nak`, and lock writes leave the lock bits unchanged.
- R7: An acknowledged command sets `busy` (0 means read-array mode) until `op_done` is seen. Commands arriving while `busy` is 1 get no response. Reset clears `busy`.
- R8: A reset sampled while `busy` is 1 gives a one-cycle `op_abort` pulse in the next cycle, and `busy` is 0 in that same cycle.
- R9: The reserved operation code (`cmd_op`=3) and sector number 7 are always rejected with `cmd_nak`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a_n | input | 1 | First reset request, active low, sampled on the clock |
| rst_b_n | input | 1 | Second reset request, active low, sampled on the clock |
| boot_lock_n | input | 1 | Boot sector guard pin, active low |
| wr_prot_n | input | 1 | General write guard pin, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 uniform erase, 3 reserved |
| cmd_sect | input | 3 | Target sector number |
| op_done | input | 1 | Running operation has finished |
| lock_we | input | 1 | Lock bit write strobe |
| lock_sect | input | 3 | Sector whose lock bit is written |
| lock_val | input | 1 | New lock value (1 = locked) |
| cmd_ack | output | 1 | Command accepted (one-cycle pulse) |
| cmd_nak | output | 1 | Command rejected (one-cycle pulse) |
| op_abort | output | 1 | Running operation aborted by reset (one-cycle pulse) |
| busy | output | 1 | Operation running; 0 means read-array mode |
| ready | output | 1 | Reset recovery complete |

## Verification
The decision is exercised with each guard pin low on its own. This shows that each pin guards only its own sectors: sector 6 for the boot pin, sectors 0 to 5 for the write pin. Uniform erases are sent to both regions under the opposite pin settings. This separates the region-based rule from the single-sector rule, and a single locked sector inside the top region shows that the whole region is checked. Requests sent before recovery ends, while busy, and with reserved codes show the silent-drop paths apart from the reject path. Reset applied during a running operation shows the abort pulse and the relocking of all sectors.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  typedef enum logic [1:0] {
    OP_PROG      = 2'd0,
    OP_SECT_ERAS = 2'd1,
    OP_UNI_ERAS  = 2'd2,
    OP_RSVD      = 2'd3
  } wp_op_e;
endpackage

// File: rtl/wp_reset_seq.sv
module wp_reset_seq #(
  parameter int RECOV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_a_n,
  input  logic rst_b_n,
  output logic rst_any,
  output logic ready
);
  localparam int CNT_W = $clog2(RECOV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign rst_any = !rst_a_n || !rst_b_n;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) ready <= 1'b1;
    end
  end

  assert_ready_low_after_reset_R6: assert property (@(posedge clk)
    rst_any |=> !ready);
  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (rst_any)
    ready |=> ready);
endmodule

// File: rtl/wp_lock_bank.sv
module wp_lock_bank #(
  parameter int NUM_SECT = 7,
  parameter int SECT_W   = 3
) (
  input  logic                clk,
  input  logic                rst_any,
  input  logic                ready,
  input  logic                wr_en,
  input  logic [SECT_W-1:0]   wr_sect,
  input  logic                wr_val,
  output logic [NUM_SECT-1:0] locks
);
  logic wr_hit;
  assign wr_hit = wr_en && ready && (int'(wr_sect) < NUM_SECT);

  always_ff @(posedge clk) begin
    if (rst_any) locks <= '1;
    else if (wr_hit) locks[wr_sect] <= wr_val;
  end

  assert_locks_set_by_reset_R5: assert property (@(posedge clk)
    rst_any |=> (locks == {NUM_SECT{1'b1}}));
  assert_locks_frozen_before_ready_R6: assert property (@(posedge clk) disable iff (rst_any)
    !ready |=> $stable(locks));
endmodule

// File: rtl/wp_permit.sv
module wp_permit
  import flash_wp_pkg::*;
#(
  parameter int NUM_SECT = 7,
  parameter int SECT_W   = 3,
  parameter int SPLIT    = 3
) (
  input  wp_op_e              op,
  input  logic [SECT_W-1:0]   sect,
  input  logic                boot_lock_n,
  input  logic                wr_prot_n,
  input  logic [NUM_SECT-1:0] locks,
  output logic                allow
);
  localparam logic [SECT_W-1:0] BOOT_IDX  = SECT_W'(NUM_SECT - 1);
  localparam logic [SECT_W-1:0] SPLIT_IDX = SECT_W'(SPLIT);

  // true when no lock bit in [lo, hi] is set
  function automatic logic range_unlocked(input logic [NUM_SECT-1:0] l,
                                          input int lo, input int hi);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_SECT; i++)
      if (i >= lo && i <= hi && l[i]) ok = 1'b0;
    return ok;
  endfunction

  logic sect_ok, boot_hit, top_region, single_ok, region_ok;

  assign sect_ok    = int'(sect) < NUM_SECT;
  assign boot_hit   = sect == BOOT_IDX;
  assign top_region = sect >= SPLIT_IDX;
  assign single_ok  = sect_ok && !locks[sect] && (boot_hit ? boot_lock_n : wr_prot_n);
  assign region_ok  = sect_ok && (top_region
                      ? (boot_lock_n && range_unlocked(locks, SPLIT, NUM_SECT - 1))
                      : (wr_prot_n   && range_unlocked(locks, 0, SPLIT - 1)));

  always_comb begin
    case (op)
      OP_PROG, OP_SECT_ERAS: allow = single_ok;
      OP_UNI_ERAS:           allow = region_ok;
      default:               allow = 1'b0;
    endcase
  end

  always_comb begin
    if (!boot_lock_n && op != OP_UNI_ERAS && boot_hit)
      assert_boot_guard_R1: assert (!allow);
    if (op == OP_RSVD || !sect_ok)
      assert_bad_code_rejected_R9: assert (!allow);
  end
endmodule

// File: rtl/wp_op_tracker.sv
module wp_op_tracker (
  input  logic clk,
  input  logic rst_any,
  input  logic ready,
  input  logic cmd_valid,
  input  logic allow,
  input  logic op_done,
  output logic ack,
  output logic nak,
  output logic busy,
  output logic abort
);
  logic take;
  assign take = cmd_valid && ready && !busy;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      ack   <= 1'b0;
      nak   <= 1'b0;
      busy  <= 1'b0;
      abort <= busy;
    end else begin
      abort <= 1'b0;
      ack   <= take && allow;
      nak   <= take && !allow;
      if (take && allow) busy <= 1'b1;
      else if (op_done)  busy <= 1'b0;
    end
  end

  assert_abort_on_busy_reset_R8: assert property (@(posedge clk)
    (rst_any && busy) |=> (abort && !busy));
  assert_single_response_R4: assert property (@(posedge clk) disable iff (rst_any)
    !(ack && nak));
  assert_ack_enters_busy_R7: assert property (@(posedge clk) disable iff (rst_any)
    ack |-> busy);
  assert_silent_while_busy_R7: assert property (@(posedge clk) disable iff (rst_any)
    (busy && !op_done) |=> (!ack && !nak));
  assert_silent_before_ready_R6: assert property (@(posedge clk) disable iff (rst_any)
    !ready |=> (!ack && !nak));
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int NUM_SECT     = 7,
  parameter int SPLIT        = 3,
  parameter int RECOV_CYCLES = 8,
  localparam int SECT_W      = $clog2(NUM_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_a_n,
  input  logic              rst_b_n,
  input  logic              boot_lock_n,
  input  logic              wr_prot_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sect,
  input  logic              op_done,
  input  logic              lock_we,
  input  logic [SECT_W-1:0] lock_sect,
  input  logic              lock_val,
  output logic              cmd_ack,
  output logic              cmd_nak,
  output logic              op_abort,
  output logic              busy,
  output logic              ready
);
  logic                rst_any;
  logic                allow;
  logic [NUM_SECT-1:0] locks;

  wp_reset_seq #(.RECOV_CYCLES(RECOV_CYCLES)) u_rst (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .rst_any(rst_any), .ready(ready)
  );

  wp_lock_bank #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_locks (
    .clk(clk), .rst_any(rst_any), .ready(ready),
    .wr_en(lock_we), .wr_sect(lock_sect), .wr_val(lock_val), .locks(locks)
  );

  wp_permit #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .SPLIT(SPLIT)) u_permit (
    .op(wp_op_e'(cmd_op)), .sect(cmd_sect), .boot_lock_n(boot_lock_n),
    .wr_prot_n(wr_prot_n), .locks(locks), .allow(allow)
  );

  wp_op_tracker u_track (
    .clk(clk), .rst_any(rst_any), .ready(ready), .cmd_valid(cmd_valid),
    .allow(allow), .op_done(op_done), .ack(cmd_ack), .nak(cmd_nak),
    .busy(busy), .abort(op_abort)
  );
endmodule

// File: tb/test_flash_wp_ctrl.sv
module test_flash_wp_ctrl;
  localparam int RECOV = 8;
  localparam int NONE = 0, ACK = 1, NAK = 2;

  logic clk = 1'b0;
  logic rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic boot_lock_n = 1'b1, wr_prot_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_sect = '0;
  logic op_done = 1'b0;
  logic lock_we = 1'b0;
  logic [2:0] lock_sect = '0;
  logic lock_val = 1'b0;
  logic cmd_ack, cmd_nak, op_abort, busy, ready;

  int n_checks = 0, n_fail = 0;

  typedef struct { int exp; string tag; } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  flash_wp_ctrl #(.RECOV_CYCLES(RECOV)) i_flash_wp_ctrl (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .boot_lock_n(boot_lock_n), .wr_prot_n(wr_prot_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sect(cmd_sect),
    .op_done(op_done), .lock_we(lock_we), .lock_sect(lock_sect),
    .lock_val(lock_val), .cmd_ack(cmd_ack), .cmd_nak(cmd_nak),
    .op_abort(op_abort), .busy(busy), .ready(ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: one response per queued command, sampled 3 ns after the edge
  always begin
    @(posedge clk);
    #3;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.tag, cmd_nak ? NAK : (cmd_ack ? ACK : NONE), it.exp);
    end else if (cmd_ack || cmd_nak) begin
      check("R4 unexpected response", 1, 0);
    end
  end

  // driver: one-cycle command; optionally retire the operation after the ack
  task automatic do_cmd(input int op, input int sect, input int exp,
                        input string tag, input bit retire = 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_sect = 3'(sect);
    sbq.push_back('{exp, tag});
    @(negedge clk);
    cmd_valid = 1'b0;
    if (exp == ACK && retire) begin
      op_done = 1'b1;
      @(negedge clk);
      op_done = 1'b0;
    end
  endtask

  task automatic set_lock(input int sect, input bit val);
    @(negedge clk);
    lock_we = 1'b1; lock_sect = 3'(sect); lock_val = val;
    @(negedge clk);
    lock_we = 1'b0;
  endtask

  task automatic wait_ready();
    repeat (RECOV) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R7 busy in reset", busy, 0);
    check("R6 ready in reset", ready, 0);
    check("R8 no abort when idle", op_abort, 0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    // R6: command and lock write during recovery are dropped
    do_cmd(0, 0, NONE, "R6 cmd before ready");
    set_lock(0, 1'b0);
    repeat (RECOV - 5) @(negedge clk);
    #3 check("R6 ready not yet", ready, 0);
    @(negedge clk); #3 check("R6 ready after interval", ready, 1);
    check("R7 read-array mode", busy, 0);
    do_cmd(0, 0, NAK, "R5 R6 lock default kept");

    for (int s = 0; s < 7; s++) set_lock(s, 1'b0);
    do_cmd(0, 0, ACK, "R4 unlocked program");
    do_cmd(1, 6, ACK, "R4 unlocked boot erase");

    boot_lock_n = 1'b0;
    do_cmd(0, 6, NAK, "R1 program boot");
    do_cmd(1, 6, NAK, "R1 erase boot");
    do_cmd(0, 5, ACK, "R1 boot pin ignores sect5");
    boot_lock_n = 1'b1; wr_prot_n = 1'b0;
    do_cmd(0, 0, NAK, "R2 program sect0");
    do_cmd(1, 5, NAK, "R2 erase sect5");
    do_cmd(0, 6, ACK, "R2 wp ignores boot");

    wr_prot_n = 1'b1; boot_lock_n = 1'b0;
    do_cmd(2, 4, NAK, "R3 uniform top, boot low");
    do_cmd(2, 1, ACK, "R3 uniform low, boot low");
    boot_lock_n = 1'b1; wr_prot_n = 1'b0;
    do_cmd(2, 3, ACK, "R3 uniform top, wp low");
    do_cmd(2, 2, NAK, "R3 uniform low, wp low");
    wr_prot_n = 1'b1;

    set_lock(4, 1'b1);
    do_cmd(2, 6, NAK, "R3 region with locked sect4");
    do_cmd(0, 4, NAK, "R4 locked sector");
    do_cmd(0, 3, ACK, "R4 neighbour unlocked");
    do_cmd(2, 0, ACK, "R3 low region clear");
    set_lock(4, 1'b0);
    do_cmd(2, 5, ACK, "R5 lock write cleared");

    do_cmd(3, 0, NAK, "R9 reserved op");
    do_cmd(0, 7, NAK, "R9 sector 7");

    do_cmd(0, 1, ACK, "R7 start op", 1'b0);
    #3 check("R7 busy after ack", busy, 1);
    do_cmd(0, 2, NONE, "R7 cmd while busy");
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    #3 check("R7 idle after done", busy, 0);

    do_cmd(1, 2, ACK, "R8 start op", 1'b0);
    @(negedge clk); rst_b_n = 1'b0;
    #3;
    check("R8 still busy before edge", busy, 1);
    @(posedge clk); #3;
    check("R8 abort pulse", op_abort, 1);
    check("R8 busy cleared", busy, 0);
    @(posedge clk); #3;
    check("R8 abort one cycle", op_abort, 0);
    @(negedge clk); rst_b_n = 1'b1;
    wait_ready();
    #3 check("R6 ready after second reset", ready, 1);
    do_cmd(0, 1, NAK, "R5 relocked by reset");
    do_cmd(2, 3, NAK, "R5 region relocked");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule